// File: doc/BRIEF.md
# NAND Flash Host Front-End

This block sits between a processor's register bus and a raw NAND flash device. Software reaches it through a small set of word registers. Writes to the command, address, write-data and read-request registers go into a shared four-entry write buffer. A pin sequencer drains that buffer in order and turns each entry into one strobe on the flash pins: a write pulse with the command latch, a write pulse with the address latch, a plain data write pulse, or a read pulse.

Single reads take two steps. The host posts any value to the read-request register. It then waits for the read-ready interrupt flag and fetches the captured word from the read register. Page transfers are started through a page-control register. A page write counts the data entries that go out. A page read issues its own read strobes once the buffer is empty. In both cases the matching pending status bit holds until the page length, in words, has been reached. A self-clearing reset register zeroes the transfer counter. Strobe widths are stretched by programmable read and write delay fields. The bus can be 8 or 16 bits wide.

The register bus is a plain write strobe plus a combinational read mux. Nothing stalls the host on that bus. Back-pressure is advisory only: the host must check the buffer-full status bit before each queued write. A write made while the buffer is full is dropped and reported through the overflow flag.

Top module: `nfc_front`

## Requirements
- R1: After reset the status register (offset 1) reads 0x10, which means only the buffer-empty bit 4 is set. The interrupt status register (offset 2) and the mask register (offset 3) read 0. The irq output is low. Both strobe pins are high, and both latch-enable pins are low.
- R2: Each entry produces exactly one write strobe, in the order the entries were written. A write to offset 4 gives a strobe with CLE=1 and ALE=0. A write to offset 5 gives a strobe with ALE=1 and CLE=0. A write to offset 6 gives a strobe with both latches low.
- R3: A write strobe holds we_n low for wr_dly+1 clock cycles. A read strobe holds re_n low for rd_dly+1 clock cycles. CTRL is at offset 0: bit0 selects the large page, bit1 selects 16-bit width, bits 5:2 hold rd_dly and bits 9:6 hold wr_dly. CTRL resets to 0x001.
- R4: A write of any value to offset 7 queues one read strobe. The word on the data-in pins is latched into the read register at offset 8, and interrupt flag bit 3 (read ready) is set.
- R5: In 8-bit mode (CTRL bit1=0), the upper data-out byte is driven to zero and the read register holds only the low input byte. In 16-bit mode, all 16 bits pass in both directions.
- R6: The buffer holds 4 entries. Status bit 1 shows full and status bit 4 shows empty. A queued write made while the buffer is full is dropped and sets interrupt bit 1. A push and a pop in the same cycle both take effect.
- R7: Interrupt bit 2 is set when the buffer goes from one entry to empty.
- R8: Status bit 0 follows the ready/busy input after a two-flop synchronizer. Interrupt bit 0 is set on each rising edge of that synchronized signal.
- R9: Writing 1 to an interrupt status bit clears it. If a set event and a clear land in the same cycle, the bit stays set.
- R10: The irq output is high exactly when some interrupt status bit and its mask bit (offset 3) are both 1.
- R11: Writing bit1 to offset 10 starts a page write. Status bit 2 stays set until a page length's worth of data entries has gone out, and then interrupt bit 4 is set. The page length in words is 256 or 512 (set by CTRL bit0), halved when CTRL bit1 selects 16-bit mode.
- R12: Writing bit0 to offset 10 starts a page read. Status bit 3 stays set while the block issues one page length of read strobes, and interrupt bit 3 is not set by them. A start request made while either page transfer is pending is ignored.
- R13: Writing 1 to bit0 of offset 9 makes that bit read 1 for RST_CYCLES (4) cycles, after which it clears itself. This also zeroes the page transfer counter, so a page in progress needs a full page length of words after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for host_addr (combinational) |
| irq | output | 1 | Masked interrupt request |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data to the flash |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_in | input | 16 | Data from the flash |
| nand_rb | input | 1 | Ready (high) / busy (low) from the flash |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a host push and a sequencer pop on the same buffer. A burst of six queued writes is made on consecutive edges while the write delay is long. The second write coincides with the pop of the first. The bench judges this by the pin log: exactly five strobes, in order, with the sixth dropped and the overflow flag set.

The second pair is a rising ready edge and a software clear of the not-busy flag. The bench times the ready input so that the synchronized edge sets the flag on the same edge that a write-one-to-clear reaches it. The flag must read back set afterwards.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int DATA_W = 16;
  localparam int REG_AW = 4;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_DATA  = 2'd2,
    K_RDREQ = 2'd3
  } ekind_t;

  typedef struct packed {
    ekind_t              kind;
    logic [DATA_W-1:0]   data;
  } wb_entry_t;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] OFS_STAT  = 4'd1;
  localparam logic [REG_AW-1:0] OFS_IRQ   = 4'd2;
  localparam logic [REG_AW-1:0] OFS_MASK  = 4'd3;
  localparam logic [REG_AW-1:0] OFS_CMD   = 4'd4;
  localparam logic [REG_AW-1:0] OFS_ADDR  = 4'd5;
  localparam logic [REG_AW-1:0] OFS_DWR   = 4'd6;
  localparam logic [REG_AW-1:0] OFS_RDREQ = 4'd7;
  localparam logic [REG_AW-1:0] OFS_READ  = 4'd8;
  localparam logic [REG_AW-1:0] OFS_RST   = 4'd9;
  localparam logic [REG_AW-1:0] OFS_PGCTL = 4'd10;

  localparam int IRQ_W  = 5;
  localparam int IB_NB  = 0;
  localparam int IB_OVF = 1;
  localparam int IB_EDG = 2;
  localparam int IB_RDY = 3;
  localparam int IB_WRD = 4;
endpackage

// File: rtl/nfc_sync.sv
module nfc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic rise
);
  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign sync_out = s2;
  assign rise     = s2 & ~s3;
endmodule

// File: rtl/nfc_wbuf.sv
module nfc_wbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int DLYW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_valid,
  input  wb_entry_t         ent,
  output logic              ent_pop,
  input  logic              page_rd_req,
  input  logic              wide,
  input  logic [DLYW-1:0]   rd_dly,
  input  logic [DLYW-1:0]   wr_dly,
  input  logic [DATA_W-1:0] dq_in,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              cap_valid,
  output logic              cap_page,
  output logic [DATA_W-1:0] cap_data,
  output logic              data_sent
);
  typedef enum logic [1:0] { S_IDLE, S_LOW, S_HIGH } st_t;

  st_t               st;
  logic [DLYW-1:0]   tmr;
  ekind_t            kind_q;
  logic              pg_q;
  logic [DATA_W-1:0] data_q;
  logic              is_rd, last_low, active;
  logic [DLYW-1:0]   dly;

  assign is_rd    = pg_q | (kind_q == K_RDREQ);
  assign dly      = is_rd ? rd_dly : wr_dly;
  assign last_low = (st == S_LOW) && (tmr == dly);
  assign active   = (st != S_IDLE);
  assign ent_pop  = (st == S_IDLE) && ent_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      kind_q <= K_CMD;
      pg_q   <= 1'b0;
      data_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          tmr <= '0;
          if (ent_valid) begin
            kind_q <= ent.kind;
            data_q <= ent.data;
            pg_q   <= 1'b0;
            st     <= S_LOW;
          end else if (page_rd_req) begin
            kind_q <= K_RDREQ;
            pg_q   <= 1'b1;
            st     <= S_LOW;
          end
        end
        S_LOW: begin
          if (tmr == dly) st <= S_HIGH;
          else            tmr <= tmr + DLYW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign we_n      = ~((st == S_LOW) & ~is_rd);
  assign re_n      = ~((st == S_LOW) & is_rd);
  assign cle       = active & ~pg_q & (kind_q == K_CMD);
  assign ale       = active & ~pg_q & (kind_q == K_ADDR);
  assign dq_oe     = active & ~is_rd;
  assign dq_out    = !dq_oe ? '0 : (wide ? data_q : {8'h00, data_q[7:0]});
  assign cap_valid = last_low & is_rd;
  assign cap_page  = pg_q;
  assign cap_data  = wide ? dq_in : {8'h00, dq_in[7:0]};
  assign data_sent = last_low & ~pg_q & (kind_q == K_DATA);
endmodule

// File: rtl/nfc_front.sv
module nfc_front
  import nfc_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int DLYW       = 4,
  parameter int PAGE_SMALL = 256,
  parameter int PAGE_LARGE = 512,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb
);
  localparam int EW  = $bits(wb_entry_t);
  localparam int FCW = $clog2(DEPTH+1);
  localparam int CW  = $clog2(PAGE_LARGE) + 1;
  localparam int RCW = $clog2(RST_CYCLES) + 1;
  localparam int CTW = 2 + 2*DLYW;

  // control fields
  logic            pg_large, wide;
  logic [DLYW-1:0] rd_dly, wr_dly;
  logic [IRQ_W-1:0] irq_stat, irq_mask, irq_set, irq_clr;
  logic [DATA_W-1:0] rd_data;
  logic            rst_busy;
  logic [RCW-1:0]  rst_tmr;
  logic            pg_rd_pend, pg_wr_pend;
  logic [CW-1:0]   pg_cnt, pg_words;

  // write buffer
  logic            q_wr, push, ovf_ev, edge_ev;
  wb_entry_t       q_ent, head;
  logic            pop, wb_full, wb_empty;
  logic [FCW-1:0]  wb_count;

  // sequencer/sync
  logic            cap_valid, cap_page, data_sent;
  logic [DATA_W-1:0] cap_data;
  logic            rb_s, rb_rise;
  logic            pg_step, pg_last, wr_done_ev, rdy_ev;
  logic            unused_bits;

  assign unused_bits = ^host_wdata;

  always_comb begin
    q_wr       = host_we && (host_addr >= OFS_CMD) && (host_addr <= OFS_RDREQ);
    q_ent.data = host_wdata;
    case (host_addr)
      OFS_CMD:  q_ent.kind = K_CMD;
      OFS_ADDR: q_ent.kind = K_ADDR;
      OFS_DWR:  q_ent.kind = K_DATA;
      default:  q_ent.kind = K_RDREQ;
    endcase
  end

  assign push    = q_wr & ~wb_full;
  assign ovf_ev  = q_wr & wb_full;
  assign edge_ev = pop & ~push & (wb_count == FCW'(1));

  nfc_wbuf #(.DEPTH(DEPTH), .W(EW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .push(push), .din(q_ent), .pop(pop),
    .dout(head), .count(wb_count), .full(wb_full), .empty(wb_empty)
  );

  nfc_seq #(.DLYW(DLYW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ent_valid(~wb_empty), .ent(head), .ent_pop(pop),
    .page_rd_req(pg_rd_pend & ~rst_busy), .wide(wide), .rd_dly(rd_dly), .wr_dly(wr_dly),
    .dq_in(nand_dq_in), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
    .cap_valid(cap_valid), .cap_page(cap_page), .cap_data(cap_data),
    .data_sent(data_sent)
  );

  nfc_sync u_rbsync (
    .clk(clk), .rst_n(rst_n), .async_in(nand_rb), .sync_out(rb_s), .rise(rb_rise)
  );

  // page accounting
  assign pg_words   = (pg_large ? CW'(PAGE_LARGE) : CW'(PAGE_SMALL)) >> wide;
  assign pg_step    = ~rst_busy & ((pg_wr_pend & data_sent) |
                                   (pg_rd_pend & cap_valid & cap_page));
  assign pg_last    = pg_step & (pg_cnt == pg_words - CW'(1));
  assign wr_done_ev = pg_last & pg_wr_pend;
  assign rdy_ev     = cap_valid & ~cap_page;

  always_comb begin
    irq_set         = '0;
    irq_set[IB_NB]  = rb_rise;
    irq_set[IB_OVF] = ovf_ev;
    irq_set[IB_EDG] = edge_ev;
    irq_set[IB_RDY] = rdy_ev;
    irq_set[IB_WRD] = wr_done_ev;
    irq_clr = (host_we && host_addr == OFS_IRQ) ? host_wdata[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_large   <= 1'b1;
      wide       <= 1'b0;
      rd_dly     <= '0;
      wr_dly     <= '0;
      irq_stat   <= '0;
      irq_mask   <= '0;
      rd_data    <= '0;
      rst_busy   <= 1'b0;
      rst_tmr    <= '0;
      pg_rd_pend <= 1'b0;
      pg_wr_pend <= 1'b0;
      pg_cnt     <= '0;
    end else begin
      irq_stat <= (irq_stat & ~irq_clr) | irq_set;
      if (cap_valid) rd_data <= cap_data;

      if (host_we && host_addr == OFS_CTRL)
        {wr_dly, rd_dly, wide, pg_large} <= host_wdata[CTW-1:0];
      if (host_we && host_addr == OFS_MASK)
        irq_mask <= host_wdata[IRQ_W-1:0];

      if (rst_busy) begin
        if (rst_tmr == RCW'(RST_CYCLES-1)) rst_busy <= 1'b0;
        else                               rst_tmr  <= rst_tmr + RCW'(1);
      end else if (host_we && host_addr == OFS_RST && host_wdata[0]) begin
        rst_busy <= 1'b1;
        rst_tmr  <= '0;
      end

      if (rst_busy)     pg_cnt <= '0;
      else if (pg_last) pg_cnt <= '0;
      else if (pg_step) pg_cnt <= pg_cnt + CW'(1);

      if (pg_last) begin
        pg_rd_pend <= 1'b0;
        pg_wr_pend <= 1'b0;
      end else if (host_we && host_addr == OFS_PGCTL && !pg_rd_pend && !pg_wr_pend) begin
        if (host_wdata[0])      pg_rd_pend <= 1'b1;
        else if (host_wdata[1]) pg_wr_pend <= 1'b1;
      end
    end
  end

  assign irq = |(irq_stat & irq_mask);

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_CTRL:  host_rdata[CTW-1:0] = {wr_dly, rd_dly, wide, pg_large};
      OFS_STAT:  host_rdata[4:0] = {wb_empty, pg_rd_pend, pg_wr_pend, wb_full, rb_s};
      OFS_IRQ:   host_rdata[IRQ_W-1:0] = irq_stat;
      OFS_MASK:  host_rdata[IRQ_W-1:0] = irq_mask;
      OFS_READ:  host_rdata = rd_data;
      OFS_RST:   host_rdata[0] = rst_busy;
      OFS_PGCTL: host_rdata[1:0] = {pg_wr_pend, pg_rd_pend};
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nfc_front_chk.sv
module nfc_front_chk
  import nfc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [REG_AW-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              wb_full,
  input logic              wb_empty,
  input logic [IRQ_W-1:0]  irq_stat,
  input logic [IRQ_W-1:0]  irq_mask,
  input logic              irq,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              rst_busy,
  input logic              pg_rd_pend,
  input logic              pg_wr_pend
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R3
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R2
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_full && wb_empty)); // R6
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr >= OFS_CMD && host_addr <= OFS_RDREQ && wb_full)
      |=> irq_stat[IB_OVF]); // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq); // R10
  AST_RST_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == OFS_RST && host_wdata[0]) |=> rst_busy); // R13
  AST_PAGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_rd_pend && pg_wr_pend)); // R12
endmodule

bind nfc_front nfc_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .wb_full(wb_full), .wb_empty(wb_empty),
  .irq_stat(irq_stat), .irq_mask(irq_mask), .irq(irq),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .rst_busy(rst_busy), .pg_rd_pend(pg_rd_pend),
  .pg_wr_pend(pg_wr_pend)
);

// File: tb/nfc_front_tb.sv
`timescale 1ns/1ps
module nfc_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = 4'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        irq, cle, ale, we_n, re_n, dq_oe;
  logic [15:0] dq_out;
  logic [15:0] dq_in = 16'hBEEF;
  logic        rb = 1'b0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nfc_front u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in), .nand_rb(rb)
  );

  // pin monitors
  int   wn = 0, rn = 0, wlow = 0, rlow = 0, wlow_last = 0, rlow_last = 0;
  logic log_cle [64];
  logic log_ale [64];
  logic [15:0] log_dq [64];

  always @(negedge clk) begin
    if (!we_n) wlow++;
    if (!re_n) rlow++;
  end
  always @(posedge we_n) if (rst_n) begin
    if (wn < 64) begin
      log_cle[wn] = cle; log_ale[wn] = ale; log_dq[wn] = dq_out;
    end
    wn++; wlow_last = wlow; wlow = 0;
  end
  always @(posedge re_n) if (rst_n) begin
    rn++; rlow_last = rlow; rlow = 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    host_addr = a; #1;
    v = host_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_stat_clear(input int bitn);
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(4'd1, v);
      if (!v[bitn]) break;
    end
  endtask

  task automatic push_data(input logic [15:0] d);
    logic [15:0] v;
    for (int i = 0; i < 1000; i++) begin
      rd(4'd1, v);
      if (!v[1]) break;
    end
    wr(4'd6, d);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(4'd1, v); chk("R1 stat", v, 16'h0010);
    rd(4'd2, v); chk("R1 irqstat", v, 0);
    rd(4'd3, v); chk("R1 mask", v, 0);
    rd(4'd0, v); chk("R3 ctrl default", v, 16'h0001);
    chk("R1 pins", {irq, cle, ale, we_n, re_n}, 5'b00011);
  endtask

  task automatic t_cmd_addr;
    wn = 0;
    wr(4'd4, 16'h0090);
    wr(4'd5, 16'h0012);
    wr(4'd6, 16'h00A7);
    idle(12);
    chk("R2 strobe count", wn, 3);
    chk("R2 cmd latch", {log_cle[0], log_ale[0]}, 2'b10);
    chk("R2 addr latch", {log_cle[1], log_ale[1]}, 2'b01);
    chk("R2 data latch", {log_cle[2], log_ale[2]}, 2'b00);
    chk("R2 order", log_dq[1], 16'h0012);
    chk("R3 we width dly0", wlow_last, 1);
  endtask

  task automatic t_read8;
    logic [15:0] v;
    wr(4'd2, 16'h001F);
    dq_in = 16'hBEEF;
    wr(4'd7, 16'h1234);
    idle(8);
    rd(4'd2, v); chk("R4 ready flag", v[3], 1);
    rd(4'd8, v); chk("R5 read 8-bit", v, 16'h00EF);
    wr(4'd2, 16'h0008);
    rd(4'd2, v); chk("R9 w1c clear", v[3], 0);
  endtask

  task automatic t_wide;
    logic [15:0] v;
    wr(4'd0, 16'h000B | (16'd3 << 6)); // large, wide, rd_dly=2, wr_dly=3
    wn = 0;
    wr(4'd6, 16'hA55A);
    wr(4'd7, 16'h0000);
    idle(20);
    chk("R5 wide out", log_dq[0], 16'hA55A);
    chk("R3 we width dly3", wlow_last, 4);
    chk("R3 re width dly2", rlow_last, 3);
    rd(4'd8, v); chk("R5 read 16-bit", v, 16'hBEEF);
    wr(4'd0, 16'h0001);
    wn = 0;
    wr(4'd6, 16'hA55A);
    idle(6);
    chk("R5 narrow out", log_dq[0], 16'h005A);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    logic [15:0] vals [6];
    vals[0] = 16'h11; vals[1] = 16'h22; vals[2] = 16'h33;
    vals[3] = 16'h44; vals[4] = 16'h55; vals[5] = 16'h66;
    wr(4'd0, 16'h0001 | (16'd15 << 6));
    wr(4'd2, 16'h001F);
    wn = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      host_we = 1'b1;
      host_addr = (i == 0) ? 4'd4 : ((i == 1) ? 4'd5 : 4'd6);
      host_wdata = vals[i];
    end
    @(negedge clk); host_we = 1'b0; #1;
    host_addr = 4'd1; #1;
    chk("R6 full bit", host_rdata[1], 1);
    rd(4'd2, v); chk("R6 overflow flag", v[1], 1);
    wait_stat_clear(3);
    idle(150);
    chk("R6 accepted count", wn, 5);
    chk("R6 last kept", log_dq[4], 16'h0055);
    chk("R3 we width dly15", wlow_last, 16);
    rd(4'd2, v); chk("R7 edge flag", v[2], 1);
    rd(4'd1, v); chk("R6 empty bit", v[4], 1);
    wr(4'd0, 16'h0001);
  endtask

  task automatic t_ready;
    logic [15:0] v;
    rb = 1'b0; idle(4);
    wr(4'd2, 16'h001F);
    rd(4'd1, v); chk("R8 busy seen", v[0], 0);
    @(negedge clk); rb = 1'b1;
    idle(4);
    rd(4'd1, v); chk("R8 ready seen", v[0], 1);
    rd(4'd2, v); chk("R8 rise flag", v[0], 1);
    chk("R10 masked off", irq, 0);
    wr(4'd3, 16'h0001);
    #1 chk("R10 irq on", irq, 1);
    wr(4'd2, 16'h0001);
    #1 chk("R10 irq off", irq, 0);
    // same-cycle set and clear
    rb = 1'b0; idle(4);
    wr(4'd2, 16'h001F);
    @(negedge clk); rb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    host_we = 1'b1; host_addr = 4'd2; host_wdata = 16'h0001;
    @(posedge clk); #1; host_we = 1'b0;
    rd(4'd2, v); chk("R9 set wins", v[0], 1);
    wr(4'd3, 16'h0000);
  endtask

  task automatic t_page_write;
    logic [15:0] v;
    wr(4'd0, 16'h0000);          // small page, 8-bit -> 256 words
    wr(4'd2, 16'h001F);
    wr(4'd10, 16'h0002);
    rd(4'd1, v); chk("R11 pending", v[2], 1);
    wr(4'd10, 16'h0001);
    rd(4'd1, v); chk("R12 start ignored", v[3], 0);
    for (int i = 0; i < 255; i++) push_data(16'(i));
    wait_stat_clear(3);
    idle(6);
    rd(4'd1, v); chk("R11 still pending", v[2], 1);
    rd(4'd2, v); chk("R11 no done yet", v[4], 0);
    push_data(16'h00FF);
    idle(6);
    rd(4'd1, v); chk("R11 pending cleared", v[2], 0);
    rd(4'd2, v); chk("R11 done flag", v[4], 1);
  endtask

  task automatic t_page_read;
    logic [15:0] v;
    wr(4'd0, 16'h0002);          // small page, 16-bit -> 128 words
    wr(4'd2, 16'h001F);
    rn = 0;
    wr(4'd10, 16'h0001);
    rd(4'd1, v); chk("R12 pending", v[3], 1);
    wait_stat_clear(3);
    idle(4);
    chk("R12 strobe count", rn, 128);
    rd(4'd2, v); chk("R12 no ready flag", v[3], 0);
  endtask

  task automatic t_reset_reg;
    logic [15:0] v;
    wr(4'd0, 16'h0003);          // large page, 16-bit -> 256 words
    wr(4'd2, 16'h001F);
    wr(4'd10, 16'h0002);
    for (int i = 0; i < 10; i++) push_data(16'(i));
    wait_stat_clear(3);
    idle(6);
    wr(4'd9, 16'h0001);
    rd(4'd9, v); chk("R13 reads busy", v[0], 1);
    idle(6);
    rd(4'd9, v); chk("R13 self clear", v[0], 0);
    for (int i = 0; i < 255; i++) push_data(16'(i));
    idle(8);
    rd(4'd1, v); chk("R13 count restarted", v[2], 1);
    push_data(16'h0001);
    idle(8);
    rd(4'd1, v); chk("R13 page done", v[2], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset;
    t_cmd_addr;
    t_read8;
    t_wide;
    t_overflow;
    t_ready;
    t_page_write;
    t_page_read;
    t_reset_reg;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule